// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Pair

This block is the interrupt-control slice of a general-purpose peripheral register set. It keeps seven pending-interrupt flags and seven matching enable bits, both reachable over a byte-wide register bus. Hardware sources raise flags through single-cycle set strobes. Software clears them in three ways: by writing ones to the flag register, or as a side effect of touching the shift-data register or the timer counter registers, which acknowledge their own sources.

The enable register takes a set-or-clear write: bit 7 of the written byte picks whether the ones in bits 6..0 turn enables on or off, so one source can be changed without first reading the register. Reading the flag register returns a summary in bit 7 that shows whether any enabled flag is pending. A single level interrupt output follows the enabled flags of the shift-complete, timer-2 and timer-1 sources.

The block holds no state machine. Its storage is two registers, the flag register and the enable register, each updated once per clock from a decoded bus access.

Top module: `irq_ctl`

## Requirements
- R1: While reset is asserted and after it, all flags and enables are zero, the interrupt output is low and a flag read returns 0x00.
- R2: A one on `src_set[i]` at a rising edge sets flag bit i, visible from that edge on. The bit positions are: shift complete 2, shift data 3, shift clock 4, timer 2 bit 5, timer 1 bit 6.
- R3: A write to address 0xE with bit 7 set ORs bits 6..0 of the data into the enables.
- R4: A write to address 0xE with bit 7 clear clears each enable whose data bit is one and leaves the other enables unchanged.
- R5: A read of address 0xE returns the enables in bits 6..0 and a one in bit 7.
- R6: A read of address 0xD returns the flags in bits 6..0. Bit 7 is one exactly when some flag is both set and enabled, in any of the seven positions.
- R7: A write to address 0xD clears each flag whose data bit is one. Zero bits and data bit 7 have no effect.
- R8: `irq` is high exactly when a flag is set and enabled in position 2, 5 or 6. Pending enabled flags in positions 0, 1, 3 and 4 do not raise it.
- R9: A read of address 0xA (shift data) clears flags 2, 3 and 4.
- R10: A read of 0x4 or a write of 0x5 or 0x7 clears flag 6. A read of 0x8 or a write of 0x9 clears flag 5. A read of 0x5 and a write of 0x4 leave both unchanged.
- R11: When a set strobe and any clear of the same flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from state and address while `bus_rd` is high, else zero |
| src_set | input | 7 | Per-source flag set strobes |
| irq | output | 1 | Level interrupt request |

## Verification
Read data comes from the registers through logic only, so a read returns the state from before the edge that ends the access. Every update from a write, an acknowledging read or a set strobe takes effect at that edge and is seen on the next access. `irq` follows the registers with no extra delay, so it changes right after the edge that changes a flag or an enable. The bench drives each access on the falling edge and compares `bus_rdata` and `irq` against its model just before the rising edge. It updates its model at that edge, so every result is checked in the cycle it is due.

// File: rtl/irq_ctl_pkg.sv
`timescale 1ns/1ps
package irq_ctl_pkg;
    localparam int DATA_W = 8;
    localparam int N_SRC  = DATA_W - 1;
    localparam int ADDR_W = 4;

    // Register addresses decoded by this block
    localparam logic [ADDR_W-1:0] A_FLAG    = 4'hD;
    localparam logic [ADDR_W-1:0] A_ENABLE  = 4'hE;
    localparam logic [ADDR_W-1:0] A_SHIFT   = 4'hA;
    localparam logic [ADDR_W-1:0] A_T1_LO   = 4'h4;
    localparam logic [ADDR_W-1:0] A_T1_HI   = 4'h5;
    localparam logic [ADDR_W-1:0] A_T1_LATH = 4'h7;
    localparam logic [ADDR_W-1:0] A_T2_LO   = 4'h8;
    localparam logic [ADDR_W-1:0] A_T2_HI   = 4'h9;

    // Source bit positions
    localparam int B_SH_DONE = 2;
    localparam int B_SH_DATA = 3;
    localparam int B_SH_CLK  = 4;
    localparam int B_TMR2    = 5;
    localparam int B_TMR1    = 6;

    localparam logic [N_SRC-1:0] SHIFT_ACK_MASK =
        (7'(1) << B_SH_DONE) | (7'(1) << B_SH_DATA) | (7'(1) << B_SH_CLK);
    localparam logic [N_SRC-1:0] IRQ_SRC_MASK =
        (7'(1) << B_SH_DONE) | (7'(1) << B_TMR2) | (7'(1) << B_TMR1);

    typedef struct packed {
        logic [N_SRC-1:0] flag_clr;   // flag bits cleared this cycle
        logic             en_wr;      // enable register written
        logic             en_set;     // 1: OR in, 0: clear
        logic [N_SRC-1:0] en_bits;    // bits carried by the enable write
        logic             sel_flag;   // read selects flag register
        logic             sel_en;     // read selects enable register
    } bus_op_t;
endpackage

// File: rtl/irq_ctl_decode.sv
`timescale 1ns/1ps
module irq_ctl_decode
    import irq_ctl_pkg::*;
(
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output bus_op_t           op
);
    logic rd_shift, rd_t1, rd_t2, wr_t1, wr_t2, wr_flag;

    always_comb begin
        rd_shift = bus_rd && (bus_addr == A_SHIFT);
        rd_t1    = bus_rd && (bus_addr == A_T1_LO);
        rd_t2    = bus_rd && (bus_addr == A_T2_LO);
        wr_t1    = bus_wr && ((bus_addr == A_T1_HI) || (bus_addr == A_T1_LATH));
        wr_t2    = bus_wr && (bus_addr == A_T2_HI);
        wr_flag  = bus_wr && (bus_addr == A_FLAG);

        op          = '0;
        op.flag_clr = (wr_flag ? bus_wdata[N_SRC-1:0] : '0)
                    | (rd_shift ? SHIFT_ACK_MASK : '0);
        op.flag_clr[B_TMR1] = op.flag_clr[B_TMR1] | rd_t1 | wr_t1;
        op.flag_clr[B_TMR2] = op.flag_clr[B_TMR2] | rd_t2 | wr_t2;
        op.en_wr    = bus_wr && (bus_addr == A_ENABLE);
        op.en_set   = bus_wdata[DATA_W-1];
        op.en_bits  = bus_wdata[N_SRC-1:0];
        op.sel_flag = bus_rd && (bus_addr == A_FLAG);
        op.sel_en   = bus_rd && (bus_addr == A_ENABLE);
    end
endmodule

// File: rtl/irq_ctl_flags.sv
`timescale 1ns/1ps
module irq_ctl_flags
    import irq_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] flag_o
);
    // One cell per source; a set strobe overrides a same-cycle clear.
    for (genvar i = 0; i < N_SRC; i++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flag_o[i] <= 1'b0;
            else if (set_i[i])
                flag_o[i] <= 1'b1;
            else if (clr_i[i])
                flag_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_ctl_enables.sv
`timescale 1ns/1ps
module irq_ctl_enables
    import irq_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             set_mode_i,
    input  logic [N_SRC-1:0] bits_i,
    output logic [N_SRC-1:0] en_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_o <= '0;
        else if (wr_i)
            en_o <= set_mode_i ? (en_o | bits_i) : (en_o & ~bits_i);
    end
endmodule

// File: rtl/irq_ctl.sv
`timescale 1ns/1ps
module irq_ctl
    import irq_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [6:0]        src_set,
    output logic              irq
);
    bus_op_t          op;
    logic [N_SRC-1:0] flag_q;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] live;

    irq_ctl_decode u_decode (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .op       (op)
    );

    irq_ctl_flags u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (src_set),
        .clr_i (op.flag_clr),
        .flag_o(flag_q)
    );

    irq_ctl_enables u_enables (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (op.en_wr),
        .set_mode_i(op.en_set),
        .bits_i    (op.en_bits),
        .en_o      (en_q)
    );

    always_comb begin
        live = flag_q & en_q;
        irq  = |(live & IRQ_SRC_MASK);
        unique case (1'b1)
            op.sel_flag: bus_rdata = {|live, flag_q};
            op.sel_en:   bus_rdata = {1'b1, en_q};
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_ctl_chk.sv
`timescale 1ns/1ps
module irq_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic [6:0] src_set,
    input logic       irq,
    input logic [6:0] flag_q,
    input logic [6:0] en_q
);
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_clear_r1: assert (flag_q == 7'h0 && en_q == 7'h0 && !irq);
        end
    end

    p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != 7'h0) |=> ((flag_q & $past(src_set)) == $past(src_set)));

    p_en_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'hE && bus_wdata[7])
        |=> (en_q == ($past(en_q) | $past(bus_wdata[6:0]))));

    p_en_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'hE && !bus_wdata[7])
        |=> (en_q == ($past(en_q) & ~$past(bus_wdata[6:0]))));

    p_en_read_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 4'hE) |-> (bus_rdata[7] && bus_rdata[6:0] == en_q));

    p_flag_summary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 4'hD) |-> (bus_rdata[7] == ((flag_q & en_q) != 7'h0)));

    p_flag_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'hD && src_set == 7'h0)
        |=> ((flag_q & $past(bus_wdata[6:0])) == 7'h0));

    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & en_q & 7'h64) == 7'h0) |-> !irq);

    p_shift_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 4'hA && src_set[4:2] == 3'b000)
        |=> (flag_q[4:2] == 3'b000));
endmodule

bind irq_ctl irq_ctl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .src_set  (src_set),
    .irq      (irq),
    .flag_q   (flag_q),
    .en_q     (en_q)
);

// File: tb/irq_ctl_tb.sv
`timescale 1ns/1ps
module irq_ctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [6:0] src_set = '0;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [6:0] m_flag = '0;
    logic [6:0] m_en   = '0;

    always #2 clk = ~clk;

    irq_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_set(src_set), .irq(irq)
    );

    function automatic logic [6:0] clr_mask(logic [3:0] a, logic wr, logic rd,
                                            logic [7:0] d);
        logic [6:0] c = '0;
        if (wr && a == 4'hD) c = d[6:0];
        if (rd && a == 4'hA) c = c | 7'b0011100;
        if ((rd && a == 4'h4) || (wr && (a == 4'h5 || a == 4'h7))) c[6] = 1'b1;
        if ((rd && a == 4'h8) || (wr && a == 4'h9)) c[5] = 1'b1;
        return c;
    endfunction

    function automatic logic [7:0] exp_read(logic [3:0] a, logic [6:0] f,
                                            logic [6:0] e);
        if (a == 4'hD) return {|(f & e), f};
        if (a == 4'hE) return {1'b1, e};
        return 8'h00;
    endfunction

    function automatic logic exp_irq(logic [6:0] f, logic [6:0] e);
        return |(f & e & 7'b1100100);
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive at falling edge, check before the rising edge,
    // then advance the model at that edge.
    task automatic step(logic [3:0] a, logic wr, logic rd, logic [7:0] d,
                        logic [6:0] s, string tag);
        @(negedge clk);
        bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = d; src_set = s;
        #1;
        if (rd) check({tag, " read"}, bus_rdata, exp_read(a, m_flag, m_en));
        check({tag, " irq R8"}, {7'h0, irq}, {7'h0, exp_irq(m_flag, m_en)});
        @(posedge clk);
        m_flag = (m_flag & ~clr_mask(a, wr, rd, d)) | s;
        if (wr && a == 4'hE)
            m_en = d[7] ? (m_en | d[6:0]) : (m_en & ~d[6:0]);
        #0;
    endtask

    task automatic rd_flag(string tag);  step(4'hD, 0, 1, 8'h00, 7'h0, tag); endtask
    task automatic rd_en(string tag);    step(4'hE, 0, 1, 8'h00, 7'h0, tag); endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        // R1 reset state, sampled while reset is still held
        @(negedge clk);
        bus_addr = 4'hD; bus_rd = 1'b1; #1;
        check("R1 flags in reset", bus_rdata, 8'h00);
        check("R1 irq in reset", {7'h0, irq}, 8'h00);
        bus_rd = 1'b0;
        rst_n = 1'b1;
        rd_flag("R1 after reset");
        rd_en("R1 R5 enables after reset");

        // R2 set strobes, R6 summary with nothing enabled
        step(4'h0, 0, 0, 8'h00, 7'b1010101, "R2 set");
        rd_flag("R2 R6 flags");
        // R3 OR-in enables, R8 irq from bit 6 only
        step(4'hE, 1, 0, 8'h81, 7'h0, "R3 en set bit0");
        rd_en("R3 enables");
        rd_flag("R6 summary from bit0, R8 irq stays low");
        step(4'hE, 1, 0, 8'hC0, 7'h0, "R3 en set bit6");
        rd_flag("R8 irq from bit6");
        // R4 clear-mode enable write
        step(4'hE, 1, 0, 8'h40, 7'h0, "R4 en clear bit6");
        rd_en("R4 enables");
        // R7 flag write clears ones only
        step(4'hD, 1, 0, 8'h85, 7'h0, "R7 w1c");
        rd_flag("R7 flags");
        // R9 shift read ack
        step(4'h0, 0, 0, 8'h00, 7'b0011100, "R9 set shift bits");
        step(4'hE, 1, 0, 8'h84, 7'h0, "R9 enable bit2");
        step(4'hA, 0, 1, 8'h00, 7'h0, "R9 shift read");
        rd_flag("R9 flags after ack");
        // R10 timer acknowledges
        step(4'hE, 1, 0, 8'hE0, 7'h0, "R10 enable timers");
        step(4'h0, 0, 0, 8'h00, 7'b1100000, "R10 set timers");
        step(4'h5, 0, 1, 8'h00, 7'h0, "R10 read t1 high no ack");
        step(4'h4, 1, 0, 8'h12, 7'h0, "R10 write t1 low no ack");
        rd_flag("R10 both still set");
        step(4'h4, 0, 1, 8'h00, 7'h0, "R10 read t1 low");
        step(4'h9, 1, 0, 8'h33, 7'h0, "R10 write t2 high");
        rd_flag("R10 both cleared");
        step(4'h0, 0, 0, 8'h00, 7'b1100000, "R10 reset timers");
        step(4'h7, 1, 0, 8'h00, 7'h0, "R10 write t1 latch high");
        step(4'h8, 0, 1, 8'h00, 7'h0, "R10 read t2 low");
        rd_flag("R10 cleared again");
        // R11 set beats clear in the same cycle
        step(4'hD, 1, 0, 8'h7F, 7'b0100001, "R11 set vs w1c");
        rd_flag("R11 flags");
        step(4'hA, 0, 1, 8'h00, 7'b0000100, "R11 set vs shift ack");
        rd_flag("R11 shift flag kept");

        // Random mix: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
        for (int i = 0; i < 800; i++) begin
            logic [3:0] a;
            logic [1:0] k;
            logic [6:0] s;
            k = 2'($urandom);
            a = ($urandom % 3 == 0) ? 4'($urandom) : (k[0] ? 4'hD : 4'hE);
            s = ($urandom % 4 == 0) ? 7'($urandom) : 7'h0;
            step(a, k == 2'd1, k != 2'd1, 8'($urandom), s, "random R6 R5");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule